// File: doc/BRIEF.md
# Single-Round AES Cipher Unit

This unit applies exactly one AES round to each 128-bit state group offered to it, so that a sequencer outside the block can build a full AES encryption or decryption by presenting the rounds one after another. A 3-bit opcode selects the round kind for each group:
- the initial key addition;
- a middle or final encryption round;
- a middle or final decryption round.

The round keys come from outside. The key schedule is not part of this block.

Two key-sourcing modes exist. In per-group mode every state group brings its own round key. In scalar mode the key offered with the start-of-stream group is captured once. That captured key is then used for every later group of the stream, whatever the key input carries.

The state and the key are 16 bytes each, laid out column-major. Byte i sits in bits 8i+7:8i and holds row i mod 4 of column i div 4. The unit takes one group per cycle without stalling, and each result appears one cycle after it is accepted. The reset is asynchronous and active-low. Its release passes through a two-stage synchronizer.

Top module: `aes_single_round`

## Requirements
- R1: While the internal reset is active, and after it is released until the first accepted group, out_valid is 0 and out_result is all zeros.
- R2: A group accepted with in_valid high at a rising edge yields out_valid high in the following cycle. Otherwise out_valid is low in the following cycle. Back-to-back groups are accepted every cycle.
- R3: Opcode 0 (zero round) gives state XOR key.
- R4: Opcode 1 (encrypt middle) gives MixColumns(ShiftRows(SubBytes(state))) XOR key. ShiftRows rotates row r left by r byte positions, so new[r][c] = old[r][(c+r) mod 4], using the column-major byte layout.
- R5: Opcode 2 (encrypt final) gives ShiftRows(SubBytes(state)) XOR key, with no MixColumns.
- R6: Opcode 3 (decrypt middle) gives InvMixColumns(InvSubBytes(InvShiftRows(state)) XOR key). The key is added before the column mixing.
- R7: Opcode 4 (decrypt final) gives InvSubBytes(InvShiftRows(state)) XOR key. InvShiftRows rotates row r right by r positions.
- R8: Opcodes 5, 6 and 7 are reserved and return the state unchanged, with the key ignored.
- R9: With in_key_scalar at 0, each group uses the key presented with it.
- R10: A group with in_sos high uses its own key and captures that key. A later group with in_key_scalar high and in_sos low uses the captured key and ignores in_key.
- R11: In a cycle after which no group was accepted, out_result keeps its previous value.
- R12: Chaining opcode 0, nine opcode-1 rounds and one opcode-2 round with AES-128 round keys reproduces the published AES-128 ciphertext. The matching decryption chain reproduces the plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| in_valid | input | 1 | A state group is offered this cycle |
| in_op | input | 3 | Round kind: 0 zero, 1 enc middle, 2 enc final, 3 dec middle, 4 dec final |
| in_key_scalar | input | 1 | 1 selects the captured stream key, 0 selects the per-group key |
| in_sos | input | 1 | First group of a stream; its key is used and captured |
| in_state | input | 128 | Input state, column-major bytes |
| in_key | input | 128 | Round key, same layout |
| out_valid | output | 1 | out_result carries a new result |
| out_result | output | 128 | Round result |

## Verification
Every result is due exactly one cycle after the rising edge that accepted its group. out_valid follows in_valid with the same one-cycle delay.

The bench reference model works from these facts:
- At each accepting edge it computes the expected round result from the inputs present at that edge, including the scalar-key capture.
- It queues that result.
- At the next falling edge it compares out_valid and the popped result.
- In idle cycles it checks instead that out_result holds.

Chained round sequences read each output at the falling edge after acceptance and feed it into the next group. This lets whole AES-128 encryption and decryption runs be compared with the published vectors.

// File: rtl/aes1r_pkg.sv
package aes1r_pkg;
  localparam int BLK_W = 128;
  localparam int NB    = BLK_W / 8;
  localparam int NCOL  = NB / 4;

  typedef enum logic [2:0] {
    OP_ZERO    = 3'd0,
    OP_ENC_MID = 3'd1,
    OP_ENC_FIN = 3'd2,
    OP_DEC_MID = 3'd3,
    OP_DEC_FIN = 3'd4
  } aes_op_e;

  function automatic logic [7:0] gf_x2(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_x2(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (0 maps to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, base;
    r    = 8'h01;
    base = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] x);
    logic [7:0] v;
    v = gf_inv(x);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox_inv(input logic [7:0] x);
    return gf_inv(rotl8(x, 1) ^ rotl8(x, 3) ^ rotl8(x, 6) ^ 8'h05);
  endfunction

  // one column, byte k = row k; inv selects the inverse coefficients
  function automatic logic [31:0] mix_col(input logic [31:0] col, input logic inv);
    logic [7:0] cf [4];
    logic [31:0] res;
    if (inv) begin
      cf[0] = 8'h0e; cf[1] = 8'h0b; cf[2] = 8'h0d; cf[3] = 8'h09;
    end else begin
      cf[0] = 8'h02; cf[1] = 8'h03; cf[2] = 8'h01; cf[3] = 8'h01;
    end
    for (int r = 0; r < 4; r++) begin
      res[8*r +: 8] = 8'h00;
      for (int k = 0; k < 4; k++)
        res[8*r +: 8] = res[8*r +: 8] ^ gf_mul(cf[(k - r + 4) % 4], col[8*k +: 8]);
    end
    return res;
  endfunction
endpackage

// File: rtl/aes1r_fwd_path.sv
module aes1r_fwd_path
  import aes1r_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] key_i,
  output logic [BLK_W-1:0] mid_o,
  output logic [BLK_W-1:0] fin_o
);
  logic [BLK_W-1:0] sub_v;
  logic [BLK_W-1:0] shf_v;
  logic [BLK_W-1:0] mix_v;

  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    localparam int ROW = gi % 4;
    localparam int COL = gi / 4;
    localparam int SRC = ROW + 4 * ((COL + ROW) % 4);
    assign sub_v[8*gi +: 8] = sbox_fwd(state_i[8*gi +: 8]);
    assign shf_v[8*gi +: 8] = sub_v[8*SRC +: 8];
  end

  for (genvar gc = 0; gc < NCOL; gc++) begin : g_col
    assign mix_v[32*gc +: 32] = mix_col(shf_v[32*gc +: 32], 1'b0);
  end

  assign fin_o = shf_v ^ key_i;
  assign mid_o = mix_v ^ key_i;
endmodule

// File: rtl/aes1r_inv_path.sv
module aes1r_inv_path
  import aes1r_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] key_i,
  output logic [BLK_W-1:0] mid_o,
  output logic [BLK_W-1:0] fin_o
);
  logic [BLK_W-1:0] shf_v;
  logic [BLK_W-1:0] sub_v;
  logic [BLK_W-1:0] add_v;

  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    localparam int ROW = gi % 4;
    localparam int COL = gi / 4;
    localparam int SRC = ROW + 4 * ((COL - ROW + 4) % 4);
    assign shf_v[8*gi +: 8] = state_i[8*SRC +: 8];
    assign sub_v[8*gi +: 8] = sbox_inv(shf_v[8*gi +: 8]);
  end

  assign add_v = sub_v ^ key_i;

  for (genvar gc = 0; gc < NCOL; gc++) begin : g_col
    assign mid_o[32*gc +: 32] = mix_col(add_v[32*gc +: 32], 1'b1);
  end

  assign fin_o = add_v;
endmodule

// File: rtl/aes1r_key_sel.sv
module aes1r_key_sel
  import aes1r_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_valid,
  input  logic             grp_sos,
  input  logic             use_scalar,
  input  logic [BLK_W-1:0] key_in,
  output logic [BLK_W-1:0] key_eff
);
  logic             cap_en;
  logic [BLK_W-1:0] held_d;
  logic [BLK_W-1:0] held_q;

  always_comb begin
    cap_en = grp_valid & grp_sos;
    held_d = key_in;
    key_eff = (use_scalar && !grp_sos) ? held_q : key_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (cap_en) held_q <= held_d;
  end

  // R10: captured key changes only on an accepted start-of-stream group
  p_held_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(grp_valid && grp_sos) |=> $stable(held_q));
endmodule

// File: rtl/aes_single_round.sv
module aes_single_round
  import aes1r_pkg::*;
#(
  parameter int RST_STAGES = 2
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       in_op,
  input  logic             in_key_scalar,
  input  logic             in_sos,
  input  logic [127:0]     in_state,
  input  logic [127:0]     in_key,
  output logic             out_valid,
  output logic [127:0]     out_result
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  logic [BLK_W-1:0] key_eff;
  logic [BLK_W-1:0] enc_mid, enc_fin, dec_mid, dec_fin;

  aes1r_key_sel u_key_sel (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .grp_valid  (in_valid),
    .grp_sos    (in_sos),
    .use_scalar (in_key_scalar),
    .key_in     (in_key),
    .key_eff    (key_eff)
  );

  aes1r_fwd_path u_fwd (
    .state_i (in_state),
    .key_i   (key_eff),
    .mid_o   (enc_mid),
    .fin_o   (enc_fin)
  );

  aes1r_inv_path u_inv (
    .state_i (in_state),
    .key_i   (key_eff),
    .mid_o   (dec_mid),
    .fin_o   (dec_fin)
  );

  logic [BLK_W-1:0] res_d, res_q;
  logic             res_en;
  logic             vld_d, vld_q;

  always_comb begin
    res_en = in_valid;
    vld_d  = in_valid;
    case (in_op)
      OP_ZERO:    res_d = in_state ^ key_eff;
      OP_ENC_MID: res_d = enc_mid;
      OP_ENC_FIN: res_d = enc_fin;
      OP_DEC_MID: res_d = dec_mid;
      OP_DEC_FIN: res_d = dec_fin;
      default:    res_d = in_state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;

  // R2: one-cycle latency, no stall
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);
  p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);
  // R11: result holds when nothing was accepted
  p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(out_result));
  // R3: zero round with per-group key
  p_zero_round_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op == 3'd0 && !in_key_scalar) |=> out_result == $past(in_state ^ in_key));
  // R8: reserved opcodes pass the state
  p_reserved_pass_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_op >= 3'd5) |=> out_result == $past(in_state));
endmodule

// File: tb/aes_single_round_bench.sv
module aes_single_round_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   in_op = 3'd0;
  logic         in_key_scalar = 1'b0;
  logic         in_sos = 1'b0;
  logic [127:0] in_state = '0;
  logic [127:0] in_key = '0;
  logic         out_valid;
  logic [127:0] out_result;

  always #2 clk = ~clk;   // 250 MHz

  aes_single_round u_aes_single_round (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] sb [256];
  logic [7:0] isb [256];
  logic [127:0] rk [11];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m2(input logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0, x = a, y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = m2(x);
      y = y >> 1;
    end
    return p;
  endfunction

  task automatic build_tables();
    logic [7:0] p = 1, q = 1, x;
    do begin
      p = p ^ m2(p);
      q ^= q << 1; q ^= q << 2; q ^= q << 4;
      if (q[7]) q ^= 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 1);
    sb[0] = 8'h63;
    for (int i = 0; i < 256; i++) isb[sb[i]] = i[7:0];
  endtask

  function automatic logic [127:0] bswap(input logic [127:0] v);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[8*i +: 8] = v[127-8*i -: 8];
    return o;
  endfunction

  function automatic logic [127:0] f_sub(input logic [127:0] s, input bit inv);
    for (int i = 0; i < 16; i++) s[8*i +: 8] = inv ? isb[s[8*i +: 8]] : sb[s[8*i +: 8]];
    return s;
  endfunction

  function automatic logic [127:0] f_shift(input logic [127:0] s, input bit inv);
    logic [127:0] t;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        if (!inv) t[8*(r+4*c) +: 8] = s[8*(r+4*((c+r)%4)) +: 8];
        else      t[8*(r+4*((c+r)%4)) +: 8] = s[8*(r+4*c) +: 8];
    return t;
  endfunction

  function automatic logic [127:0] f_mix(input logic [127:0] s, input bit inv);
    logic [7:0] cf [4];
    logic [127:0] t = '0;
    cf = inv ? '{8'h0e, 8'h0b, 8'h0d, 8'h09} : '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        for (int k = 0; k < 4; k++)
          t[8*(r+4*c) +: 8] ^= mul(cf[(k-r+4)%4], s[8*(k+4*c) +: 8]);
    return t;
  endfunction

  function automatic logic [127:0] ref_round(input logic [2:0] op, input logic [127:0] s, input logic [127:0] k);
    case (op)
      3'd0: return s ^ k;
      3'd1: return f_mix(f_shift(f_sub(s, 0), 0), 0) ^ k;
      3'd2: return f_shift(f_sub(s, 0), 0) ^ k;
      3'd3: return f_mix(f_sub(f_shift(s, 1), 1) ^ k, 1);
      3'd4: return f_sub(f_shift(s, 1), 1) ^ k;
      default: return s;
    endcase
  endfunction

  task automatic expand_key(input logic [127:0] key);
    logic [7:0] rc = 8'h01;
    logic [7:0] t [4];
    rk[0] = key;
    for (int r = 1; r <= 10; r++) begin
      for (int j = 0; j < 4; j++) t[j] = sb[rk[r-1][8*(12 + (j+1)%4) +: 8]];
      t[0] ^= rc;
      rc = m2(rc);
      for (int j = 0; j < 16; j++)
        rk[r][8*j +: 8] = rk[r-1][8*j +: 8] ^ ((j < 4) ? t[j] : rk[r][8*(j-4) +: 8]);
    end
  endtask

  // ---------------- reference model, compared every cycle ----------------
  logic [127:0] exp_q [$];
  string        tag_q [$];
  logic         exp_vld = 0;
  logic [127:0] m_held = '0;
  logic [127:0] last_out = '0;
  bit           mon_on = 0;

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_vld <= 1'b0;
      m_held = '0;
    end else begin
      exp_vld <= in_valid;
      if (in_valid) begin
        logic [127:0] k;
        k = (in_key_scalar && !in_sos) ? m_held : in_key;
        exp_q.push_back(ref_round(in_op, in_state, k));
        tag_q.push_back((in_key_scalar && !in_sos) ? {"R10/", op_tag(in_op)} : {"R9/", op_tag(in_op)});
        if (in_sos) m_held = in_key;
      end
    end
  end

  always @(negedge clk) begin
    if (mon_on && !done) begin
      chk(out_valid === exp_vld, "R2 valid", {127'd0, out_valid}, {127'd0, exp_vld});
      if (exp_vld) begin
        logic [127:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_result === e, t, out_result, e);
        last_out = e;
      end else begin
        chk(out_result === last_out, "R11 hold", out_result, last_out);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive_one(input logic [2:0] op, input logic [127:0] s, input logic [127:0] k,
                           output logic [127:0] res);
    in_valid = 1; in_op = op; in_state = s; in_key = k; in_key_scalar = 0; in_sos = 0;
    @(negedge clk);
    in_valid = 0;
    res = out_result;
  endtask

  task automatic drive_grp(input logic [2:0] op, input bit scal, input bit sos,
                           input logic [127:0] s, input logic [127:0] k);
    in_valid = 1; in_op = op; in_key_scalar = scal; in_sos = sos; in_state = s; in_key = k;
    @(negedge clk);
    in_valid = 0; in_sos = 0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2 actual=hung expected=completion");
    finish_run();
  end

  initial begin
    logic [127:0] s, pt, ct, key;
    build_tables();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(out_valid === 1'b0, "R1 valid", {127'd0, out_valid}, '0);
    chk(out_result === '0, "R1 result", out_result, '0);
    mon_on = 1;
    @(negedge clk);

    // R12: known-answer chains (each step also checked by the model)
    key = bswap(128'h000102030405060708090a0b0c0d0e0f);
    pt  = bswap(128'h00112233445566778899aabbccddeeff);
    ct  = bswap(128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    expand_key(key);
    drive_one(3'd0, pt, rk[0], s);
    for (int r = 1; r <= 9; r++) drive_one(3'd1, s, rk[r], s);
    drive_one(3'd2, s, rk[10], s);
    chk(s === ct, "R12 encrypt", s, ct);
    drive_one(3'd0, ct, rk[10], s);
    for (int r = 9; r >= 1; r--) drive_one(3'd3, s, rk[r], s);
    drive_one(3'd4, s, rk[0], s);
    chk(s === pt, "R12 decrypt", s, pt);
    @(negedge clk);

    // R9/R2: back-to-back per-group keys, all opcodes
    for (int i = 0; i < 40; i++) begin
      in_valid = 1; in_op = 3'($urandom_range(0, 4)); in_key_scalar = 0; in_sos = 0;
      in_state = rnd128(); in_key = rnd128();
      @(negedge clk);
    end
    in_valid = 0;
    @(negedge clk);

    // R10: scalar stream; in_key varies but the captured key must be used
    drive_grp(3'd1, 1, 1, rnd128(), 128'hA5A5_0000_1111_2222_3333_4444_5555_6666);
    for (int i = 0; i < 12; i++) drive_grp(3'($urandom_range(0, 4)), 1, 0, rnd128(), rnd128());
    drive_grp(3'd4, 1, 1, rnd128(), rnd128());  // recapture
    for (int i = 0; i < 6; i++) drive_grp(3'($urandom_range(0, 4)), 1, 0, rnd128(), rnd128());
    drive_grp(3'd0, 0, 0, rnd128(), rnd128());  // R9 in between scalar groups
    drive_grp(3'd0, 1, 0, rnd128(), rnd128());

    // R8: reserved opcodes
    for (int op = 5; op < 8; op++) drive_grp(3'(op), 0, 0, rnd128(), rnd128());

    // R11/R2: sparse traffic with idle gaps
    for (int i = 0; i < 20; i++) begin
      drive_grp(3'($urandom_range(0, 7)), 0, 0, rnd128(), rnd128());
      repeat (i % 3) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule